// File: doc/BRIEF.md
# Clamping Add, Subtract and Average Unit

This unit is an arithmetic stage for signal-processing and media datapaths. It adds or subtracts two WIDTH-bit operands. When the true result falls outside what WIDTH bits can hold, it returns the nearest end of the range instead of wrapping. It never signals an interrupt, so every result takes the same number of cycles. A third operation returns the mean of the two operands, rounded toward minus infinity. The mean is formed at full precision, so the carry of the sum is kept as the top bit before the shift. The same operations work on unsigned numbers or on two's-complement numbers, chosen by one select line.

Each accepted operation gives a registered result one clock later, marked by an output strobe. A sticky indicator records that at least one accepted operation was clamped. A small state machine holds this indicator in one of two states, ST_CLEAN and ST_STICKY:

- The "set" transition goes from ST_CLEAN to ST_STICKY on a clamped accepted operation.
- The "clear" transition goes from ST_STICKY to ST_CLEAN when the clear input is high and no clamped operation arrives in the same cycle.
- In every other cycle the "hold" transition keeps the current state.

Top module: `sat_alu_unit`

## Requirements
- R1: While reset is asserted, and after it is released before any operation is accepted, `res_q` is 0, `res_valid` is 0 and `sat_sticky` is 0.
- R2: An operation accepted with `in_valid` high at a rising edge updates `res_q` and raises `res_valid` at that edge. `res_valid` is 0 in the cycle after a cycle with `in_valid` low, and `res_q` holds its value.
- R3: With `op_sel`=0 (add) and `is_signed`=0, the result is a+b. If a+b exceeds 2^WIDTH-1, the result is all ones. For WIDTH=4, 0111+1001 gives 1111, not the wrapped 0000.
- R4: With `op_sel`=1 (subtract) and `is_signed`=0, the result is a-b. If b>a, the result is 0.
- R5: With `op_sel`=0 and `is_signed`=1, the operands are two's complement and the result is a+b. It is clamped to 0111…1 above the range and to 1000…0 below it.
- R6: With `op_sel`=1 and `is_signed`=1, the result is a-b with the same clamping as R5.
- R7: With `op_sel`=2 (average) and `is_signed`=0, the result is floor((a+b)/2) with the carry kept. For WIDTH=4, 0111 and 1001 give 1000: neither 0000 (wrap, then shift) nor 0111 (clamp, then shift).
- R8: With `op_sel`=2 and `is_signed`=1, the result is floor((a+b)/2) of the two's-complement values. The average never counts as clamped.
- R9: `op_sel`=3 behaves exactly as add (`op_sel`=0), in both signed and unsigned mode.
- R10: A clamped accepted operation sets `sat_sticky` at the same edge that presents its result. The flag then stays 1 through non-clamped operations and idle cycles while `flag_clr` is low.
- R11: `flag_clr` high at an edge clears `sat_sticky` unless a clamped operation is accepted at that same edge, in which case the flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 2 | 0 add, 1 subtract, 2 average, 3 add |
| is_signed | input | 1 | 1: two's complement, 0: unsigned |
| opnd_a | input | WIDTH | First operand (minuend for subtract) |
| opnd_b | input | WIDTH | Second operand |
| flag_clr | input | 1 | Clears the sticky clamp indicator |
| res_q | output | WIDTH | Registered result |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| sat_sticky | output | 1 | Sticky clamp indicator |

## Verification
A fault in the datapath appears at `res_q` one edge after the operation that triggers it, so every operation is compared against an independent range model at that edge. A fault in the indicator state machine appears on `sat_sticky` at the same edge. Examples are a missed set, a clear that loses to nothing, or a state that drifts while idle. Because the bench carries its own model of the flag across every operation and idle cycle, such a fault is reported on the first cycle where the two diverge, not only at the end.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD     = 2'd0,
        OP_SUB     = 2'd1,
        OP_HALF    = 2'd2,
        OP_ADD_ALT = 2'd3
    } op_e;

    typedef enum logic {
        ST_CLEAN  = 1'b0,
        ST_STICKY = 1'b1
    } flag_st_e;

endpackage

// File: rtl/sat_core.sv
module sat_core
    import sat_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       op,
    input  logic             is_signed,
    output logic [WIDTH-1:0] y,
    output logic             clamp
);
    localparam int EW = WIDTH + 1;
    localparam logic [WIDTH-1:0] S_MAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] S_MIN = {1'b1, {(WIDTH-1){1'b0}}};

    logic [EW-1:0] ext_a, ext_b, sum_x, dif_x;
    op_e           op_q;

    assign op_q  = op_e'(op);
    assign ext_a = is_signed ? {a[WIDTH-1], a} : {1'b0, a};
    assign ext_b = is_signed ? {b[WIDTH-1], b} : {1'b0, b};
    assign sum_x = ext_a + ext_b;
    assign dif_x = ext_a - ext_b;

    always_comb begin
        y     = sum_x[WIDTH-1:0];
        clamp = 1'b0;
        unique case (op_q)
            OP_ADD, OP_ADD_ALT: begin
                if (!is_signed) begin
                    if (sum_x[WIDTH]) begin
                        y     = '1;
                        clamp = 1'b1;
                    end
                end else if (sum_x[WIDTH] != sum_x[WIDTH-1]) begin
                    y     = sum_x[WIDTH] ? S_MIN : S_MAX;
                    clamp = 1'b1;
                end
            end
            OP_SUB: begin
                y = dif_x[WIDTH-1:0];
                if (!is_signed) begin
                    if (dif_x[WIDTH]) begin
                        y     = '0;
                        clamp = 1'b1;
                    end
                end else if (dif_x[WIDTH] != dif_x[WIDTH-1]) begin
                    y     = dif_x[WIDTH] ? S_MIN : S_MAX;
                    clamp = 1'b1;
                end
            end
            OP_HALF: begin
                y = sum_x[WIDTH:1];
            end
        endcase
    end

    // R8: the average can never leave the range
    always_comb begin
        if (op_q == OP_HALF) begin
            a_r8_half_no_clamp: assert (!clamp);
        end
    end

endmodule

// File: rtl/sat_flag_fsm.sv
module sat_flag_fsm
    import sat_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sat_evt,
    input  logic clr,
    output logic flag
);
    flag_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CLEAN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAN:  if (sat_evt)         st_d = ST_STICKY;
            ST_STICKY: if (clr && !sat_evt) st_d = ST_CLEAN;
        endcase
    end

    always_comb begin
        flag = (st_q == ST_STICKY);
    end

    a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
        sat_evt |=> flag);
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !sat_evt) |=> !flag);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !sat_evt) |=> $stable(flag));

endmodule

// File: rtl/sat_alu_unit.sv
module sat_alu_unit
    import sat_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] res_q,
    output logic             res_valid,
    output logic             sat_sticky
);
    logic [WIDTH-1:0] core_y;
    logic             core_clamp;
    logic             sat_evt;

    sat_core #(.WIDTH(WIDTH)) u_core (
        .a         (opnd_a),
        .b         (opnd_b),
        .op        (op_sel),
        .is_signed (is_signed),
        .y         (core_y),
        .clamp     (core_clamp)
    );

    assign sat_evt = in_valid & core_clamp;

    sat_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .sat_evt (sat_evt),
        .clr     (flag_clr),
        .flag    (sat_sticky)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) res_q <= core_y;
        end
    end

    a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(res_q)));
    a_r3_top_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0 && !is_signed && core_clamp) |=> (res_q == '1));
    a_r4_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd1 && !is_signed) |=> (res_q <= $past(opnd_a)));
    a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0 && is_signed && opnd_a[WIDTH-1] == opnd_b[WIDTH-1])
        |=> (res_q[WIDTH-1] == $past(opnd_a[WIDTH-1])));

endmodule

// File: tb/test_sat_alu_unit.sv
module test_sat_alu_unit;
    localparam int W    = 4;
    localparam int FULL = 1 << W;
    localparam int HALF = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op_sel = 2'd0;
    logic         is_signed = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] res_q;
    logic         res_valid;
    logic         sat_sticky;

    int checks = 0;
    int fails  = 0;
    bit mflag  = 1'b0;
    int last_res = 0;

    always #2 clk = ~clk;

    sat_alu_unit #(.WIDTH(W)) i_sat_alu_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .is_signed(is_signed), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .flag_clr(flag_clr), .res_q(res_q), .res_valid(res_valid),
        .sat_sticky(sat_sticky)
    );

    function automatic int model(int a, int b, int op, bit sgn, output bit sat);
        int va, vb, r, lo, hi;
        va  = (sgn && a >= HALF) ? a - FULL : a;
        vb  = (sgn && b >= HALF) ? b - FULL : b;
        lo  = sgn ? -HALF : 0;
        hi  = sgn ? HALF - 1 : FULL - 1;
        sat = 1'b0;
        if (op == 2)      r = (va + vb) >>> 1;
        else if (op == 1) r = va - vb;
        else              r = va + vb;
        if (r > hi) begin r = hi; sat = 1'b1; end
        else if (r < lo) begin r = lo; sat = 1'b1; end
        return r & (FULL - 1);
    endfunction

    function automatic string op_tag(int op, bit sgn);
        if (op == 3) return "R9";
        if (op == 2) return sgn ? "R8" : "R7";
        if (op == 1) return sgn ? "R6" : "R4";
        return sgn ? "R5" : "R3";
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(int a, int b, int op, bit sgn, bit clr);
        bit s;
        int e;
        @(negedge clk);
        in_valid  = 1'b1;
        opnd_a    = a[W-1:0];
        opnd_b    = b[W-1:0];
        op_sel    = op[1:0];
        is_signed = sgn;
        flag_clr  = clr;
        e = model(a, b, op, sgn, s);
        @(posedge clk);
        #1;
        mflag    = s ? 1'b1 : (clr ? 1'b0 : mflag);
        last_res = e;
        chk(op_tag(op, sgn), int'(res_q), e);
        chk("R2", int'(res_valid), 1);
        chk(clr ? "R11" : "R10", int'(sat_sticky), int'(mflag));
    endtask

    task automatic idle(bit clr);
        @(negedge clk);
        in_valid = 1'b0;
        flag_clr = clr;
        opnd_a   = ~opnd_a;
        @(posedge clk);
        #1;
        if (clr) mflag = 1'b0;
        chk("R2", int'(res_valid), 0);
        chk("R2", int'(res_q), last_res);
        chk(clr ? "R11" : "R10", int'(sat_sticky), int'(mflag));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20110214);
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(res_q), 0);
        chk("R1", int'(res_valid), 0);
        chk("R1", int'(sat_sticky), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", int'(res_valid), 0);
        chk("R1", int'(sat_sticky), 0);

        // R3: unsigned clamp on the 0111 + 1001 case
        apply(7, 9, 0, 0, 0);
        chk("R3", int'(res_q), 15);
        idle(0);
        idle(1);
        // R7: average keeps the carry
        apply(7, 9, 2, 0, 0);
        chk("R7", int'(res_q != 4'b0000), 1);
        chk("R7", int'(res_q != 4'b0111), 1);
        chk("R7", int'(res_q), 8);
        apply(15, 15, 2, 0, 0);
        apply(3, 5, 1, 0, 0);    // R4 borrow
        apply(7, 1, 0, 1, 0);    // R5 above range
        apply(8, 15, 0, 1, 0);   // R5 below range
        apply(8, 1, 1, 1, 0);    // R6 below range
        apply(7, 8, 1, 1, 0);    // R6 above range
        apply(8, 15, 2, 1, 0);   // R8 negative floor
        apply(7, 7, 2, 1, 0);    // R8
        apply(12, 9, 3, 0, 0);   // R9
        apply(6, 5, 3, 1, 1);    // R9 with R11 set wins
        apply(1, 2, 0, 0, 1);    // R11 clear
        apply(2, 1, 0, 0, 0);    // R10 stays clean
        idle(0);

        for (int i = 0; i < 600; i++) begin
            int ra, rb, rop;
            bit rs, rc;
            ra  = int'($urandom_range(FULL - 1));
            rb  = int'($urandom_range(FULL - 1));
            rop = int'($urandom_range(3));
            rs  = 1'($urandom_range(1));
            rc  = ($urandom_range(7) == 0);
            if ($urandom_range(9) == 0) idle(rc);
            else apply(ra, rb, rop, rs, rc);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule